// File: doc/BRIEF.md
# Multiply-Accumulate Sequencer

This block walks two arrays of signed elements held in a byte-addressed memory and accumulates the sum of their pairwise products. A start pulse supplies the two starting addresses, an element count, an element size and a 96-bit starting sum given as three 32-bit words. The block then reads through a synchronous memory port with a one-cycle read latency. For each pair it reads the element from the first array, then the element from the second. It sign-extends both, multiplies them as signed 32-bit values and adds the 64-bit product into the running sum.

When the count runs out, the block limits the sum to a signed 80-bit value by filling the upper half of the top word from bit 15 of that word. It then presents the final three words, a sign flag, an overflow flag and a computed cycle cost, and marks completion with a one-cycle `done` pulse. The caller supplies addresses and the starting sum and takes the results. The block does no instruction decode and no register writeback.

Top module: `mac_seq`

## Requirements
- R1: `size_sel` selects the element size: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The element is taken from the low bytes of `mem_rdata`, where byte 0 (bits 7:0) holds the byte at the read address. It is sign-extended to 32 bits.
- R2: Each pair of elements is multiplied as two signed 32-bit values, giving a full signed 64-bit product.
- R3: The product is sign-extended to 96 bits and added modulo 2^96 to the sum `{hi, mid, lo}`. Carries ripple from the low word into the middle word and then into the top word.
- R4: Each step reads the first-array element one cycle before the second-array element. After the step, both addresses advance by the element size in bytes and the remaining count drops by one. Step k reads `ptr_a + k*size` and `ptr_b + k*size`.
- R5: At completion, bits 31:16 of `sum_hi` are all ones if bit 15 of the accumulated top word is set, and all zeros if it is clear. Bits 15:0 of `sum_hi` and all of `sum_mid` and `sum_lo` are kept as accumulated.
- R6: `flag_neg` equals bit 31 of the final `sum_hi`. `flag_ovf` is 1 exactly when the final `sum_hi` is neither 0x00000000 nor 0xFFFFFFFF.
- R7: `cycle_cost` for n elements is 6+4n for 4-byte elements, 6+5*(n/2)+4*(n%2) for 2-byte elements, and 6+7*(n/4)+4*(n%4) for 1-byte elements, using integer division.
- R8: A `start` seen while `busy` is high is ignored. The run in progress finishes with its own result, and no second completion follows.
- R9: A count of zero completes without any memory read. `sum_lo` and `sum_mid` equal the starting words, and `sum_hi` is the starting top word after the R5 fill. The cost is 6.
- R10: `busy` is high from the cycle after an accepted start until completion. `done` is a single-cycle pulse, with `busy` low during it. The result outputs hold their values until the next completion.
- R11: Synchronous reset clears `busy`, `done`, `mem_rd_en`, the three result words, both flags and `cycle_cost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run; sampled only while idle |
| size_sel | input | 2 | Element size code (R1) |
| ptr_a | input | AW | Byte address of the first array |
| ptr_b | input | AW | Byte address of the second array |
| count | input | CW | Number of element pairs |
| acc_lo_in | input | 32 | Starting sum, bits 31:0 |
| acc_mid_in | input | 32 | Starting sum, bits 63:32 |
| acc_hi_in | input | 32 | Starting sum, bits 95:64 |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Completion pulse |
| sum_lo | output | 32 | Final sum, bits 31:0 |
| sum_mid | output | 32 | Final sum, bits 63:32 |
| sum_hi | output | 32 | Final sum, bits 95:64, after the fill |
| flag_neg | output | 1 | Sign of the final sum |
| flag_ovf | output | 1 | Final top word is not a pure sign extension |
| cycle_cost | output | COSTW | Computed cycle cost |

## Verification
An internal fault surfaces as a wrong sum at the single `done` pulse of that run. Those errors include an address stepping by the wrong size, a lost carry between words, or an element taken as unsigned. The sum is the only place the bench can see them, so every vector compares all 96 bits. The memory holds bytes with both signs, so a sign error always changes the result. A state machine that re-arms on a start arriving mid-run shows up as a second `done` pulse in the idle window the bench watches after the first. A zero count that still reads memory shows up as a read request seen at the port.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;
  localparam int DW    = 32;          // element / word width
  localparam int NWORD = 3;           // words in the running sum
  localparam int SUMW  = DW * NWORD;  // running sum width
  localparam int KEEPW = 80;          // signed width kept at completion

  typedef enum logic [2:0] {
    S_IDLE,
    S_RDA,
    S_RDB,
    S_MAC,
    S_FIN
  } mac_state_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/mac_seq_elem_ext.sv
module mac_seq_elem_ext
  import mac_seq_pkg::*;
(
  input  logic [DW-1:0]        raw,
  input  logic [1:0]           size_sel,
  output logic signed [DW-1:0] val
);
  always_comb begin
    case (size_sel)
      2'd0:    val = {{(DW-8){raw[7]}}, raw[7:0]};
      2'd1:    val = {{(DW-16){raw[15]}}, raw[15:0]};
      default: val = raw;
    endcase
  end
endmodule

// File: rtl/mac_seq_accum.sv
module mac_seq_accum
  import mac_seq_pkg::*;
(
  input  logic signed [DW-1:0] op_a,
  input  logic signed [DW-1:0] op_b,
  input  logic [SUMW-1:0]      acc_in,
  output logic [SUMW-1:0]      acc_out
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic [SUMW-1:0]      addend;
  logic [NWORD-1:0]     carry;

  assign prod     = op_a * op_b;
  assign addend   = {{(SUMW-PW){prod[PW-1]}}, prod};
  assign carry[0] = 1'b0;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    if (w < NWORD - 1) begin : g_mid
      logic [DW:0] s;
      assign s = {1'b0, acc_in[w*DW +: DW]} + {1'b0, addend[w*DW +: DW]}
               + {{DW{1'b0}}, carry[w]};
      assign acc_out[w*DW +: DW] = s[DW-1:0];
      assign carry[w+1]          = s[DW];
    end else begin : g_top
      assign acc_out[w*DW +: DW] = acc_in[w*DW +: DW] + addend[w*DW +: DW]
                                 + {{(DW-1){1'b0}}, carry[w]};
    end
  end
endmodule

// File: rtl/mac_seq_cost.sv
module mac_seq_cost #(
  parameter int CW    = 16,
  parameter int COSTW = 32
) (
  input  logic [1:0]       size_sel,
  input  logic [CW-1:0]    n,
  output logic [COSTW-1:0] cost
);
  logic [COSTW-1:0] n_w;
  assign n_w = COSTW'(n);

  always_comb begin
    case (size_sel)
      2'd0:    cost = COSTW'(6) + COSTW'(7) * (n_w >> 2) + COSTW'(4) * (n_w & COSTW'(3));
      2'd1:    cost = COSTW'(6) + COSTW'(5) * (n_w >> 1) + COSTW'(4) * (n_w & COSTW'(1));
      default: cost = COSTW'(6) + COSTW'(4) * n_w;
    endcase
  end
endmodule

// File: rtl/mac_seq.sv
module mac_seq
  import mac_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int COSTW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       size_sel,
  input  logic [AW-1:0]    ptr_a,
  input  logic [AW-1:0]    ptr_b,
  input  logic [CW-1:0]    count,
  input  logic [DW-1:0]    acc_lo_in,
  input  logic [DW-1:0]    acc_mid_in,
  input  logic [DW-1:0]    acc_hi_in,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    sum_lo,
  output logic [DW-1:0]    sum_mid,
  output logic [DW-1:0]    sum_hi,
  output logic             flag_neg,
  output logic             flag_ovf,
  output logic [COSTW-1:0] cycle_cost
);
  localparam int TOPLO = 2 * DW;           // first bit of the top word
  localparam int FILLW = SUMW - KEEPW;     // bits replaced by the fill

  mac_state_e              state_q;
  logic [AW-1:0]           ptr_a_q, ptr_b_q;
  logic [CW-1:0]           cnt_q, n_tot_q;
  logic [1:0]              size_q;
  logic signed [DW-1:0]    a_q;
  logic [SUMW-1:0]         acc_q;

  logic signed [DW-1:0]    elem_val;
  logic [SUMW-1:0]         acc_nxt;
  logic [COSTW-1:0]        cost_val;
  logic [AW-1:0]           step;
  logic [DW-1:0]           hi_fill;

  mac_seq_elem_ext u_ext (
    .raw      (mem_rdata),
    .size_sel (size_q),
    .val      (elem_val)
  );

  mac_seq_accum u_acc (
    .op_a    (a_q),
    .op_b    (elem_val),
    .acc_in  (acc_q),
    .acc_out (acc_nxt)
  );

  mac_seq_cost #(.CW(CW), .COSTW(COSTW)) u_cost (
    .size_sel (size_q),
    .n        (n_tot_q),
    .cost     (cost_val)
  );

  assign step    = AW'(size_bytes(size_q));
  assign hi_fill = {{FILLW{acc_q[KEEPW-1]}}, acc_q[KEEPW-1:TOPLO]};

  assign busy      = (state_q != S_IDLE);
  assign mem_rd_en = (state_q == S_RDA) || (state_q == S_RDB);
  assign mem_addr  = (state_q == S_RDB) ? ptr_b_q : ptr_a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      ptr_a_q    <= '0;
      ptr_b_q    <= '0;
      cnt_q      <= '0;
      n_tot_q    <= '0;
      size_q     <= '0;
      a_q        <= '0;
      acc_q      <= '0;
      done       <= 1'b0;
      sum_lo     <= '0;
      sum_mid    <= '0;
      sum_hi     <= '0;
      flag_neg   <= 1'b0;
      flag_ovf   <= 1'b0;
      cycle_cost <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            ptr_a_q <= ptr_a;
            ptr_b_q <= ptr_b;
            cnt_q   <= count;
            n_tot_q <= count;
            size_q  <= size_sel;
            acc_q   <= {acc_hi_in, acc_mid_in, acc_lo_in};
            state_q <= (count == '0) ? S_FIN : S_RDA;
          end
        end
        S_RDA: state_q <= S_RDB;
        S_RDB: begin
          a_q     <= elem_val;
          state_q <= S_MAC;
        end
        S_MAC: begin
          acc_q   <= acc_nxt;
          ptr_a_q <= ptr_a_q + step;
          ptr_b_q <= ptr_b_q + step;
          cnt_q   <= cnt_q - CW'(1);
          state_q <= (cnt_q == CW'(1)) ? S_FIN : S_RDA;
        end
        S_FIN: begin
          sum_lo     <= acc_q[DW-1:0];
          sum_mid    <= acc_q[2*DW-1:DW];
          sum_hi     <= hi_fill;
          flag_neg   <= hi_fill[DW-1];
          flag_ovf   <= (hi_fill != '0) && (hi_fill != '1);
          cycle_cost <= cost_val;
          done       <= 1'b1;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10: completion is a single pulse, and the block is idle during it
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: run configuration cannot change once a run is under way
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> ($stable(size_q) && $stable(n_tot_q)));

  // R4: per-step address advance and count decrement
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_MAC) |=> ((ptr_a_q == $past(ptr_a_q) + $past(step)) &&
                            (ptr_b_q == $past(ptr_b_q) + $past(step)) &&
                            (cnt_q == $past(cnt_q) - CW'(1))));

  // R4: the second-array read directly follows the first-array read
  p_read_order_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RDA) |=> (mem_rd_en && (mem_addr == ptr_b_q)));

  // R9: zero count goes straight to completion with no read
  p_zero_noread_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && start && count == '0) |=> (!mem_rd_en ##1 done));

  // R5: final top word is a sign extension of its bit 15
  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (sum_hi[DW-1:KEEPW-TOPLO] == {FILLW{sum_hi[KEEPW-TOPLO-1]}}));

  // R6: sign flag follows the final top word
  p_neg_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (flag_neg == sum_hi[DW-1]));
endmodule

// File: tb/tb_mac_seq.sv
`timescale 1ns/1ps
module tb_mac_seq;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int COSTW = 32;

  typedef struct packed {
    logic [1:0]  sz;
    logic [7:0]  n;
    logic [7:0]  pa;
    logic [7:0]  pb;
    logic [95:0] acc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 8'd3, 8'd0,   8'd64,  96'h0},
    '{2'd1, 8'd5, 8'd10,  8'd100, 96'h0},
    '{2'd0, 8'd7, 8'd3,   8'd200, 96'h0},
    '{2'd0, 8'd4, 8'd17,  8'd33,  {32'h00000000, 32'hffffffff, 32'hffffff00}},
    '{2'd2, 8'd2, 8'd128, 8'd136, {32'h00008000, 32'h00000000, 32'h00000000}},
    '{2'd1, 8'd1, 8'd50,  8'd51,  {32'h12340000, 32'h00000000, 32'h00000005}},
    '{2'd2, 8'd8, 8'd160, 8'd96,  {32'hffffffff, 32'h00000000, 32'h00000000}},
    '{2'd0, 8'd6, 8'd77,  8'd140, {32'h00000000, 32'h7fffffff, 32'hfffffff0}},
    '{2'd3, 8'd1, 8'd220, 8'd4,   96'h0}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             start;
  logic [1:0]       size_sel;
  logic [AW-1:0]    ptr_a, ptr_b;
  logic [CW-1:0]    count;
  logic [31:0]      acc_lo_in, acc_mid_in, acc_hi_in;
  logic             mem_rd_en;
  logic [AW-1:0]    mem_addr;
  logic [31:0]      mem_rdata;
  logic             busy, done;
  logic [31:0]      sum_lo, sum_mid, sum_hi;
  logic             flag_neg, flag_ovf;
  logic [COSTW-1:0] cycle_cost;

  logic [7:0] mem [0:255];
  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  mac_seq #(.AW(AW), .CW(CW), .COSTW(COSTW)) dut (
    .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .count(count),
    .acc_lo_in(acc_lo_in), .acc_mid_in(acc_mid_in), .acc_hi_in(acc_hi_in),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .sum_lo(sum_lo), .sum_mid(sum_mid),
    .sum_hi(sum_hi), .flag_neg(flag_neg), .flag_ovf(flag_ovf),
    .cycle_cost(cycle_cost)
  );

  // synchronous memory, one-cycle read latency, little-endian bytes
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                    mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
    end
  end

  // ---------------- reference model ----------------
  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic signed [31:0] elem(input logic [7:0] addr, input int nb);
    logic [31:0] raw;
    raw = {mem[addr + 8'd3], mem[addr + 8'd2], mem[addr + 8'd1], mem[addr]};
    if (nb == 1) return {{24{raw[7]}}, raw[7:0]};
    if (nb == 2) return {{16{raw[15]}}, raw[15:0]};
    return raw;
  endfunction

  function automatic logic [95:0] model_sum(input vec_t v);
    logic [95:0] acc;
    int nb;
    acc = v.acc;
    nb  = nbytes(v.sz);
    for (int k = 0; k < int'(v.n); k++) begin
      logic signed [31:0] a, b;
      longint p;
      a = elem(8'(int'(v.pa) + k*nb), nb);
      b = elem(8'(int'(v.pb) + k*nb), nb);
      p = longint'(a) * longint'(b);
      acc = acc + {{32{p[63]}}, p};
    end
    acc[95:80] = {16{acc[79]}};
    return acc;
  endfunction

  function automatic int model_cost(input logic [1:0] sz, input int n);
    if (sz == 2'd0) return 6 + 7*(n/4) + 4*(n%4);
    if (sz == 2'd1) return 6 + 5*(n/2) + 4*(n%2);
    return 6 + 4*n;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    start      = 1'b1;
    size_sel   = v.sz;
    ptr_a      = AW'(v.pa);
    ptr_b      = AW'(v.pb);
    count      = CW'(v.n);
    acc_lo_in  = v.acc[31:0];
    acc_mid_in = v.acc[63:32];
    acc_hi_in  = v.acc[95:64];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_result(input string tag, input vec_t v);
    logic [95:0] es;
    es = model_sum(v);
    chk({tag, " R2 R3 R4 R5 sum"}, {sum_hi, sum_mid, sum_lo}, es);
    chk({tag, " R6 neg"}, 96'(flag_neg), 96'(es[95]));
    chk({tag, " R6 ovf"}, 96'(flag_ovf), 96'((es[95:64] != 32'h0) && (es[95:64] != 32'hffffffff)));
    chk({tag, " R7 cost"}, 96'(cycle_cost), 96'(model_cost(v.sz, int'(v.n))));
    chk({tag, " R10 busy low at done"}, 96'(busy), 96'(0));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 73 + 29);
    rst = 1'b1; start = 1'b0; size_sel = '0; ptr_a = '0; ptr_b = '0;
    count = '0; acc_lo_in = '0; acc_mid_in = '0; acc_hi_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11: reset state
    chk("R11 busy", 96'(busy), 96'(0));
    chk("R11 done", 96'(done), 96'(0));
    chk("R11 rd_en", 96'(mem_rd_en), 96'(0));
    chk("R11 sum", {sum_hi, sum_mid, sum_lo}, 96'h0);
    chk("R11 flags", 96'({flag_neg, flag_ovf}), 96'(0));
    chk("R11 cost", 96'(cycle_cost), 96'(0));

    // vector table: R1 sizes, R3 carries, R5 fill, R6 flags, R7 cost
    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      chk("R10 busy after start", 96'(busy), 96'(1));
      wait_done();
      check_result($sformatf("vec%0d R1", i), VECS[i]);
    end

    // R10: outputs hold after completion
    begin
      logic [95:0] held;
      held = {sum_hi, sum_mid, sum_lo};
      repeat (5) @(negedge clk);
      chk("R10 result held", {sum_hi, sum_mid, sum_lo}, held);
    end

    // R9: zero count, no read, start words kept (top word filled)
    begin
      vec_t z;
      bit saw_rd;
      z = '{2'd2, 8'd0, 8'd0, 8'd0, {32'h00000005, 32'hdeadbeef, 32'h01234567}};
      saw_rd = 1'b0;
      launch(z);
      while (!done) begin
        if (mem_rd_en) saw_rd = 1'b1;
        @(negedge clk);
      end
      chk("R9 no read", 96'(saw_rd), 96'(0));
      chk("R9 sum", {sum_hi, sum_mid, sum_lo}, {32'h00000005, 32'hdeadbeef, 32'h01234567});
      chk("R9 cost", 96'(cycle_cost), 96'(6));
      chk("R9 ovf", 96'(flag_ovf), 96'(1));
    end

    // R8: start while busy is ignored
    begin
      int extra;
      launch(VECS[0]);
      repeat (3) @(negedge clk);
      start = 1'b1; size_sel = 2'd0; count = CW'(2);
      ptr_a = AW'(5); ptr_b = AW'(9); acc_hi_in = 32'h00000777;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check_result("R8 busy-start", VECS[0]);
      extra = 0;
      repeat (20) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      chk("R8 no second run", 96'(extra), 96'(0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule